// File: doc/BRIEF.md
# Bridge Memory Window Forwarder

This block makes the forwarding decision for memory requests that cross a PCI-to-PCI bridge or a root port. Each request arrives with an address and a flag that tells which side of the bridge it was seen on. The block compares the address with two programmable windows. The first is a 32-bit window for non-prefetchable memory. The second is a prefetchable window that can reach the full 64-bit space.

A request that arrives from the primary side is claimed and sent downstream when it falls inside either window. A request that arrives from the secondary side is sent upstream only when it lies outside both windows. This lets devices behind the bridge write to system memory by DMA. The bridge can also be built as the one subtractive-decode agent on its bus. In that role it claims primary-side requests that no window matched and no peer device claimed.

The result is registered and appears one clock after the request.

Top module: `bwf_top`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released with no request, `dec_valid`, `fwd_down`, `fwd_up` and `sub_claim` are all 0.
- R2: A primary-side request (`req_from_sec`=0) with address bits 63:32 equal to zero and bits 31:20 in the inclusive range [`np_base`, `np_limit`] gives `fwd_down`=1 one clock later. This holds for every low-order byte of the limit megabyte, up to bits 19:0 all ones.
- R3: A primary-side request whose address bits 63:20 lie within the inclusive range [{`pf_base_hi`,`pf_base_lo`}, {`pf_limit_hi`,`pf_limit_lo`}] gives `fwd_down`=1 one clock later.
- R4: A window whose base is greater than its limit matches no address.
- R5: When `mem_en` is 0, primary-side requests produce neither `fwd_down` nor `sub_claim`.
- R6: A secondary-side request gives `fwd_up`=1 exactly when its address is outside both windows, whatever the value of `mem_en`. A secondary-side request never gives `fwd_down` or `sub_claim`.
- R7: With `SUB_DECODE`=1 and `mem_en`=1, a primary-side request that misses both windows while `peer_claim`=0 gives `fwd_down`=1 and `sub_claim`=1. If `peer_claim`=1, it gives no forward.
- R8: An address with any of bits 63:32 set never matches the non-prefetchable window.
- R9: A cycle with `req_valid`=0 gives `dec_valid`=0 and all decision outputs 0 one clock later. When `req_valid`=1, `dec_valid`=1 one clock later.
- R10: An address that matches both windows at once is forwarded downstream once, with `sub_claim`=0. `fwd_down` and `fwd_up` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_en | input | 1 | Memory space enable for downstream claiming |
| np_base | input | 12 | Non-prefetchable window base, address bits 31:20 |
| np_limit | input | 12 | Non-prefetchable window limit, address bits 31:20, inclusive |
| pf_base_lo | input | 12 | Prefetchable base, address bits 31:20 |
| pf_limit_lo | input | 12 | Prefetchable limit, address bits 31:20 |
| pf_base_hi | input | 32 | Prefetchable base, address bits 63:32 |
| pf_limit_hi | input | 32 | Prefetchable limit, address bits 63:32 |
| peer_claim | input | 1 | Another agent on the primary bus claimed the request |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 64 | Request byte address |
| req_from_sec | input | 1 | 1 = request seen on the secondary side |
| dec_valid | output | 1 | Decision present |
| fwd_down | output | 1 | Request claimed and forwarded downstream |
| fwd_up | output | 1 | Request forwarded upstream |
| sub_claim | output | 1 | Downstream claim was made by subtractive decode |

## Verification
A single address can match both windows in the same cycle. The windows can also disagree, with one of them disabled by base greater than limit while the other matches. The bench provokes both cases. It programs the two windows over the same megabytes and sends primary-side and secondary-side requests into the overlap. It also draws random configurations in which the windows often collide. Each result is judged against a bench model. For a primary-side request in the overlap, the model expects exactly one downstream forward and no subtractive claim. For a secondary-side request in the overlap, it expects no upstream forward.

// File: rtl/bwf_pkg.sv
// Package bwf_pkg
// Shared widths and the route encoding used by the memory window forwarder.
// Assumes byte addresses and a window granularity of 2**GRAN_SHIFT bytes.
package bwf_pkg;
    localparam int ADDR_W     = 64;
    localparam int LOW_W      = 32;
    localparam int GRAN_SHIFT = 20;
    localparam int NP_W       = LOW_W - GRAN_SHIFT;
    localparam int PF_W       = ADDR_W - GRAN_SHIFT;
    localparam int HI_W       = ADDR_W - LOW_W;

    typedef enum logic [1:0] {
        ROUTE_NONE = 2'd0,
        ROUTE_DOWN = 2'd1,
        ROUTE_UP   = 2'd2
    } route_e;
endpackage

// File: rtl/bwf_range_cmp.sv
// Module bwf_range_cmp
// Inclusive range comparator on granule numbers. It reports a hit when
// base <= key <= limit. A range whose base exceeds its limit never hits.
// Assumes key, base and limit are already aligned to the same granule.
module bwf_range_cmp #(
    parameter int W = 12
) (
    input  logic [W-1:0] key,
    input  logic [W-1:0] base,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic enabled;

    // Purpose: decide whether the range is programmed and holds the key.
    always_comb begin
        enabled = (base <= limit);
        hit     = enabled && (key >= base) && (key <= limit);
    end
endmodule

// File: rtl/bwf_route.sv
// Module bwf_route
// Turns the window hits and the request context into a route. Primary-side
// requests go down on a window hit, or by subtractive decode when that is
// built in. Secondary-side requests go up only when outside every window.
// Assumes the hits are already qualified by address width.
module bwf_route
    import bwf_pkg::*;
#(
    parameter bit SUB_DECODE = 1'b1
) (
    input  logic   valid,
    input  logic   from_sec,
    input  logic   mem_en,
    input  logic   peer_claim,
    input  logic   hit_np,
    input  logic   hit_pf,
    output route_e route,
    output logic   sub
);
    logic any_hit;
    logic pos_claim;
    logic sub_take;

    // Purpose: positive decode on primary side, inverse decode on secondary side.
    always_comb begin
        any_hit   = hit_np || hit_pf;
        pos_claim = valid && !from_sec && mem_en && any_hit;
        sub_take  = SUB_DECODE && valid && !from_sec && mem_en &&
                    !any_hit && !peer_claim;
        sub       = sub_take;
        if (pos_claim || sub_take) begin
            route = ROUTE_DOWN;
        end else if (valid && from_sec && !any_hit) begin
            route = ROUTE_UP;
        end else begin
            route = ROUTE_NONE;
        end
    end
endmodule

// File: rtl/bwf_top.sv
// Module bwf_top
// Memory window forwarder for a bridge or root port. It compares each
// request address against a 32-bit non-prefetchable window and a prefetchable
// window that can be 32- or 64-bit (PF_64). It registers a
// down/up/subtractive decision one clock after the request.
// Assumes window registers are stable while requests flow.
module bwf_top
    import bwf_pkg::*;
#(
    parameter bit SUB_DECODE = 1'b1,
    parameter bit PF_64      = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_en,
    input  logic [NP_W-1:0]   np_base,
    input  logic [NP_W-1:0]   np_limit,
    input  logic [NP_W-1:0]   pf_base_lo,
    input  logic [NP_W-1:0]   pf_limit_lo,
    input  logic [HI_W-1:0]   pf_base_hi,
    input  logic [HI_W-1:0]   pf_limit_hi,
    input  logic              peer_claim,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_from_sec,
    output logic              dec_valid,
    output logic              fwd_down,
    output logic              fwd_up,
    output logic              sub_claim
);
    logic   upper_zero;
    logic   np_raw;
    logic   hit_np;
    logic   hit_pf;
    route_e route;
    logic   sub;

    // Purpose: flag addresses that fit in the low 4 GB.
    always_comb begin
        upper_zero = (req_addr[ADDR_W-1:LOW_W] == '0);
    end

    bwf_range_cmp #(.W(NP_W)) u_np_cmp (
        .key   (req_addr[LOW_W-1:GRAN_SHIFT]),
        .base  (np_base),
        .limit (np_limit),
        .hit   (np_raw)
    );

    // Purpose: the non-prefetchable window only covers the low 4 GB.
    always_comb begin
        hit_np = np_raw && upper_zero;
    end

    generate
        if (PF_64) begin : g_pf64
            bwf_range_cmp #(.W(PF_W)) u_pf_cmp (
                .key   (req_addr[ADDR_W-1:GRAN_SHIFT]),
                .base  ({pf_base_hi, pf_base_lo}),
                .limit ({pf_limit_hi, pf_limit_lo}),
                .hit   (hit_pf)
            );
        end else begin : g_pf32
            logic pf_raw;
            bwf_range_cmp #(.W(NP_W)) u_pf_cmp (
                .key   (req_addr[LOW_W-1:GRAN_SHIFT]),
                .base  (pf_base_lo),
                .limit (pf_limit_lo),
                .hit   (pf_raw)
            );
            // Purpose: a 32-bit prefetchable window also stops at 4 GB.
            always_comb begin
                hit_pf = pf_raw && upper_zero;
            end
        end
    endgenerate

    bwf_route #(.SUB_DECODE(SUB_DECODE)) u_route (
        .valid      (req_valid),
        .from_sec   (req_from_sec),
        .mem_en     (mem_en),
        .peer_claim (peer_claim),
        .hit_np     (hit_np),
        .hit_pf     (hit_pf),
        .route      (route),
        .sub        (sub)
    );

    // Purpose: register the decision with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            fwd_down  <= 1'b0;
            fwd_up    <= 1'b0;
            sub_claim <= 1'b0;
        end else begin
            dec_valid <= req_valid;
            fwd_down  <= (route == ROUTE_DOWN);
            fwd_up    <= (route == ROUTE_UP);
            sub_claim <= sub;
        end
    end

    // R1: reset clears every output on the next edge.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> !dec_valid && !fwd_down && !fwd_up && !sub_claim);

    // R5: disabled memory space makes no downstream claim.
    assert_memen_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_from_sec && !mem_en) |=> !fwd_down && !sub_claim);

    // R6: secondary-side requests never go down.
    assert_sec_no_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_from_sec) |=> !fwd_down && !sub_claim);

    // R7: a subtractive claim is always a downstream forward.
    assert_sub_is_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sub_claim |-> fwd_down && !fwd_up);

    // R7: a claimed peer request never draws a subtractive claim.
    assert_peer_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && peer_claim) |=> !sub_claim);

    // R9: idle cycles give no decision.
    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !dec_valid && !fwd_down && !fwd_up && !sub_claim);

    // R10: at most one direction is chosen.
    assert_one_dir_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fwd_down, fwd_up}));

    // R10: a decision only exists for a valid request.
    assert_dec_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_down || fwd_up) |-> dec_valid);
endmodule

// File: tb/bwf_top_tb.sv
`timescale 1ns/1ps
module bwf_top_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        mem_en;
    logic [11:0] np_base, np_limit, pf_base_lo, pf_limit_lo;
    logic [31:0] pf_base_hi, pf_limit_hi;
    logic        peer_claim, req_valid, req_from_sec;
    logic [63:0] req_addr;
    logic        dec_valid, fwd_down, fwd_up, sub_claim;
    int          n_chk = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    bwf_top u_dut (
        .clk(clk), .rst_n(rst_n), .mem_en(mem_en),
        .np_base(np_base), .np_limit(np_limit),
        .pf_base_lo(pf_base_lo), .pf_limit_lo(pf_limit_lo),
        .pf_base_hi(pf_base_hi), .pf_limit_hi(pf_limit_hi),
        .peer_claim(peer_claim), .req_valid(req_valid),
        .req_addr(req_addr), .req_from_sec(req_from_sec),
        .dec_valid(dec_valid), .fwd_down(fwd_down),
        .fwd_up(fwd_up), .sub_claim(sub_claim)
    );

    // Expected {valid, down, up, sub} from the requirements.
    function automatic logic [3:0] model(input logic v, input logic [63:0] a,
                                         input logic sec, input logic peer);
        logic np_hit, pf_hit, any;
        logic [43:0] pb, pl;
        if (!v) return 4'b0000;
        np_hit = (a[63:32] == 32'd0) && (np_base <= np_limit) &&
                 (a[31:20] >= np_base) && (a[31:20] <= np_limit);
        pb = {pf_base_hi, pf_base_lo};
        pl = {pf_limit_hi, pf_limit_lo};
        pf_hit = (pb <= pl) && (a[63:20] >= pb) && (a[63:20] <= pl);
        any = np_hit || pf_hit;
        if (sec) return any ? 4'b1000 : 4'b1010;
        if (mem_en && any) return 4'b1100;
        if (mem_en && !peer) return 4'b1101;
        return 4'b1000;
    endfunction

    task automatic report;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic compare(input logic [3:0] exp, input string tag);
        logic [3:0] act;
        act = {dec_valid, fwd_down, fwd_up, sub_claim};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h actual=%b expected=%b", tag, req_addr, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [11:0] nb, input logic [11:0] nl,
                           input logic [11:0] pbl, input logic [11:0] pll,
                           input logic [31:0] pbh, input logic [31:0] plh,
                           input logic en);
        @(negedge clk);
        np_base = nb; np_limit = nl; pf_base_lo = pbl; pf_limit_lo = pll;
        pf_base_hi = pbh; pf_limit_hi = plh; mem_en = en; req_valid = 1'b0;
    endtask

    // Drive at a falling edge, sample at the next falling edge (one register).
    task automatic txn(input logic v, input logic [63:0] a, input logic sec,
                       input logic peer, input string tag);
        logic [3:0] exp;
        @(negedge clk);
        req_valid = v; req_addr = a; req_from_sec = sec; peer_claim = peer;
        exp = model(v, a, sec, peer);
        @(negedge clk);
        compare(exp, tag);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; mem_en = 1'b1; req_valid = 1'b1; req_from_sec = 1'b0;
        req_addr = 64'h1000_0000; peer_claim = 1'b0;
        np_base = 12'h100; np_limit = 12'h1FF; pf_base_lo = 12'h800;
        pf_limit_lo = 12'h9FF; pf_base_hi = 32'd1; pf_limit_hi = 32'd1;
        repeat (3) @(negedge clk);
        compare(4'b0000, "R1 in reset");
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        compare(4'b0000, "R1 after reset");

        set_cfg(12'h100, 12'h1FF, 12'h800, 12'h9FF, 32'd1, 32'd1, 1'b1);
        txn(1, 64'h0000_0000_1000_0000, 0, 1, "R2 base");
        txn(1, 64'h0000_0000_1FFF_FFFF, 0, 1, "R2 limit inclusive");
        txn(1, 64'h0000_0000_2000_0000, 0, 1, "R2 above limit");
        txn(1, 64'h0000_0000_0FFF_FFFF, 0, 1, "R2 below base");
        txn(1, 64'h0000_0001_1000_0000, 0, 1, "R8 upper bits");
        txn(1, 64'h0000_0001_8000_0000, 0, 1, "R3 base");
        txn(1, 64'h0000_0001_9FFF_FFFF, 0, 1, "R3 limit");
        txn(1, 64'h0000_0000_8000_0000, 0, 1, "R3 wrong high");
        txn(1, 64'h0000_0000_1000_0000, 1, 0, "R6 inside np");
        txn(1, 64'h0000_0000_3000_0000, 1, 0, "R6 outside");
        txn(1, 64'h0000_0001_8000_0000, 1, 0, "R6 inside pf");
        txn(1, 64'h0000_0000_3000_0000, 0, 0, "R7 subtractive");
        txn(1, 64'h0000_0000_3000_0000, 0, 1, "R7 peer claimed");
        txn(0, 64'h0000_0000_1000_0000, 0, 0, "R9 idle");
        txn(0, 64'h0000_0000_3000_0000, 1, 0, "R9 idle sec");

        set_cfg(12'h100, 12'h1FF, 12'h800, 12'h9FF, 32'd1, 32'd1, 1'b0);
        txn(1, 64'h0000_0000_1000_0000, 0, 0, "R5 window");
        txn(1, 64'h0000_0000_3000_0000, 0, 0, "R5 subtractive");
        txn(1, 64'h0000_0000_3000_0000, 1, 0, "R5 R6 upstream");
        txn(1, 64'h0000_0000_1000_0000, 1, 0, "R5 R6 inside");

        set_cfg(12'h200, 12'h100, 12'h800, 12'h9FF, 32'd1, 32'd1, 1'b1);
        txn(1, 64'h0000_0000_1800_0000, 0, 1, "R4 np disabled");
        txn(1, 64'h0000_0000_1800_0000, 1, 0, "R4 np disabled sec");
        set_cfg(12'h100, 12'h1FF, 12'h900, 12'h800, 32'd1, 32'd1, 1'b1);
        txn(1, 64'h0000_0001_8800_0000, 0, 1, "R4 pf disabled");
        set_cfg(12'h100, 12'h1FF, 12'h800, 12'h800, 32'd2, 32'd1, 1'b1);
        txn(1, 64'h0000_0001_8000_0000, 0, 1, "R4 pf high disabled");

        set_cfg(12'h100, 12'h1FF, 12'h100, 12'h1FF, 32'd0, 32'd0, 1'b1);
        txn(1, 64'h0000_0000_1500_0000, 0, 0, "R10 overlap");
        txn(1, 64'h0000_0000_1500_0000, 1, 0, "R10 overlap sec");

        for (int blk = 0; blk < 12; blk++) begin
            logic [11:0] nb, pb;
            logic [31:0] ph;
            nb = 12'($urandom_range(0, 4095));
            pb = 12'($urandom_range(0, 4095));
            ph = 32'($urandom_range(0, 3));
            set_cfg(nb, 12'(nb + $urandom_range(0, 300) - 20),
                    pb, 12'(pb + $urandom_range(0, 300) - 20),
                    ph, 32'(ph + $urandom_range(0, 1)),
                    1'($urandom_range(0, 7) != 0));
            for (int k = 0; k < 40; k++) begin
                logic [63:0] a;
                a = {32'($urandom_range(0, 3)), 32'($urandom)};
                case ($urandom_range(0, 3))
                    0: a[31:20] = 12'(np_base + $urandom_range(0, 2) - 1);
                    1: a[31:20] = 12'(np_limit + $urandom_range(0, 2) - 1);
                    2: a[31:20] = 12'(pf_limit_lo + $urandom_range(0, 2) - 1);
                    default: ;
                endcase
                txn(1'($urandom_range(0, 9) != 0), a, 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 1)), "R2 R3 R6 R7 R9 random");
            end
        end

        report();
        $finish;
    end
endmodule